// File: doc/BRIEF.md
# LCD pixel clock divider

This block produces the pixel clock for a panel from one of two candidate sources. A 32-bit timing word, held inside the block and reached through a plain write/read port, holds the divide setting. A 10-bit divisor code sits in two separate fields of that word. In normal operation the pixel clock runs at the source rate divided by the code plus two. A bypass bit instead passes the selected source straight through. One more bit picks the source, and another inverts the output, so that panel data can change on the opposite edge. The other polarity bits are only stored for neighbouring logic.

Both sources reach the block as clock-enable strobes in the block's own clock domain, one strobe per source cycle. Every period count below is in source cycles. New settings are taken from the word only when the divider counter returns to zero. A write therefore never cuts a period short. Each new period is marked by a tick output that lasts one source cycle.

Top module: `pixclk_div`

## Requirements
- R1: After reset the timing word reads 0x00000000. The output divides source 0 by 2. In the first source cycle after reset the pixel clock is high and the tick is high.
- R2: A write replaces the whole timing word, and every bit reads back unchanged from the next cycle on. This includes bits 11, 12 and 14.
- R3: The 10-bit divisor code takes its bits [4:0] from word bits [4:0] and its bits [9:5] from word bits [31:27]. With bit 26 clear, the pixel clock period is code+2 source cycles.
- R4: The high phase lasts floor((code+2)/2) source cycles, and the low phase lasts the rest of the period. This also holds for odd ratios.
- R5: With word bit 26 set, the divisor fields are ignored. The pixel clock then equals the selected source strobe, and the tick is held high.
- R6: Word bit 5 = 0 selects source 0, and word bit 5 = 1 selects source 1.
- R7: Word bit 13 = 1 inverts the pixel clock output. The uninverted clock then drives the tick, so the output is low while the tick is high.
- R8: Word bits 11, 12 and 14 have no effect on the pixel clock or the tick.
- R9: A change of divisor code, source, bypass or inversion takes effect only when the counter wraps to zero. The period that is running when the write lands completes with its old high and low lengths.
- R10: Outside bypass, the tick is high for exactly one source cycle, starting at each rising edge of the uninverted pixel clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| src0_en | input | 1 | Source 0 strobe, one pulse per source cycle |
| src1_en | input | 1 | Source 1 strobe, one pulse per source cycle |
| wr_en | input | 1 | Timing word write enable |
| wr_data | input | 32 | Timing word write data |
| rd_data | output | 32 | Timing word read data |
| pix_clk | output | 1 | Pixel clock, optionally inverted |
| pix_tick | output | 1 | Pulse at each rising edge of the uninverted pixel clock |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running period. It must leave that period untouched and act only from the next one. To get there, the stimulus watches the pixel clock and writes a much shorter ratio in the cycle right after a rising edge. It then measures the rest of that period and the one after it. The source-select and bypass cases use a second strobe at one third of the clock rate. This makes the effect of a source change plain in the measured phase lengths.

// File: rtl/pixclk_div.sv
module pixclk_div (
  input  logic        clk,
  input  logic        rst,
  input  logic        src0_en,
  input  logic        src1_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pix_clk,
  output logic        pix_tick
);
  localparam int LO_W    = 5;
  localparam int HI_W    = 5;
  localparam int CODE_W  = LO_W + HI_W;
  localparam int CNT_W   = CODE_W + 1;
  localparam int HI_LSB  = 32 - HI_W;
  localparam int SEL_BIT = 5;
  localparam int INV_BIT = 13;
  localparam int BYP_BIT = 26;

  logic [31:0]       cfg;
  logic [CODE_W-1:0] act_code;
  logic              act_byp, act_sel, act_inv;
  logic [CNT_W-1:0]  cnt;

  wire              se    = act_sel ? src1_en : src0_en;
  wire [CNT_W-1:0]  ratio = {1'b0, act_code} + CNT_W'(2);
  wire [CNT_W-1:0]  half  = ratio >> 1;
  wire              wrap  = act_byp || (cnt == ratio - CNT_W'(1));
  wire              pix_raw = act_byp ? se : (cnt < half);

  assign rd_data  = cfg;
  assign pix_clk  = pix_raw ^ act_inv;
  assign pix_tick = act_byp | (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_code <= '0;
      act_byp  <= 1'b0;
      act_sel  <= 1'b0;
      act_inv  <= 1'b0;
    end else if (se) begin
      if (wrap) begin
        cnt      <= '0;
        act_code <= {cfg[31:HI_LSB], cfg[LO_W-1:0]};
        act_byp  <= cfg[BYP_BIT];
        act_sel  <= cfg[SEL_BIT];
        act_inv  <= cfg[INV_BIT];
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pixclk_div_chk.sv
module pixclk_div_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        pix_tick,
  input logic        pix_raw,
  input logic        act_byp,
  input logic [9:0]  act_code,
  input logic [10:0] cnt
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data == $past(wr_data)));

  // R5
  byp_tick_chk: assert property (@(posedge clk) disable iff (rst)
    act_byp |-> pix_tick);

  // R10
  rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pix_raw) && !act_byp) |-> pix_tick);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != 11'd0) |-> $stable(act_code));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= ({1'b0, act_code} + 11'd1));
endmodule

bind pixclk_div pixclk_div_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pix_tick(pix_tick), .pix_raw(pix_raw), .act_byp(act_byp),
  .act_code(act_code), .cnt(cnt)
);

// File: tb/sim_pixclk_div.sv
module sim_pixclk_div;
  localparam int PERIOD = 10;
  localparam int NV = 7;
  localparam logic [31:0] VCFG [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                                        32'h0000_001F, 32'h0800_0000, 32'hF800_001F,
                                        32'h0000_5802};
  localparam int VHI [NV] = '{1, 1, 2, 16, 17, 512, 2};
  localparam int VLO [NV] = '{1, 2, 2, 17, 17, 513, 2};

  logic clk = 0, rst = 1, wr_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic pix_clk, pix_tick, src1_en;
  logic src0_en = 1'b1;
  logic [1:0] c3;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) c3 <= 0;
    else     c3 <= (c3 == 2) ? 2'd0 : c3 + 2'd1;
  end
  assign src1_en = (c3 == 0);

  pixclk_div u0 (.clk(clk), .rst(rst), .src0_en(src0_en), .src1_en(src1_en),
                 .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
                 .pix_clk(pix_clk), .pix_tick(pix_tick));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(output int hi, output int lo, output int tk);
    while (pix_clk !== 1'b0) @(negedge clk);
    while (pix_clk !== 1'b1) @(negedge clk);
    hi = 0; lo = 0; tk = 0;
    while (pix_clk == 1'b1) begin hi++; tk += int'(pix_tick); @(negedge clk); end
    while (pix_clk == 1'b0) begin lo++; tk += int'(pix_tick); @(negedge clk); end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, tk, bad;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk(rd_data == 32'h0, "R1 word", int'(rd_data), 0);
    chk(pix_clk == 1'b1 && pix_tick == 1'b1, "R1 first cycle", int'({pix_clk, pix_tick}), 3);
    @(negedge clk);
    measure(hi, lo, tk);
    chk(hi == 1 && lo == 1, "R1 div2", hi * 10 + lo, 11);

    // R3 R4 R8 R10 table walk, source 0 strobes every cycle
    for (int i = 0; i < NV; i++) begin
      wr(VCFG[i]);
      measure(hi, lo, tk);
      measure(hi, lo, tk);
      chk(hi == VHI[i], "R3/R4 high", hi, VHI[i]);
      chk(lo == VLO[i], "R3/R4 low", lo, VLO[i]);
      chk(tk == 1, "R10 tick width", tk, 1);
    end
    // R8 last vector carried bits 11,12,14; R2 readback
    chk(rd_data == 32'h0000_5802, "R2 R8 readback", int'(rd_data), 32'h5802);
    wr(32'hA5C3_7E19);
    chk(rd_data == 32'hA5C3_7E19, "R2 full word", int'(rd_data), 32'hA5C3_7E19);

    // R6 source 1 (one strobe per 3 clocks), code 0
    wr(32'h0000_0020);
    measure(hi, lo, tk);
    measure(hi, lo, tk);
    chk(hi == 3 && lo == 3, "R6 source1 phases", hi * 10 + lo, 33);
    chk(tk == 3, "R6 R10 tick one source cycle", tk, 3);

    // R5 bypass on source 1
    wr(32'h0400_0025);
    repeat (10) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 9; k++) begin
      if (pix_clk !== src1_en || pix_tick !== 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 bypass follows source", bad, 0);

    // R7 inversion, source 0, code 0
    wr(32'h0000_2000);
    repeat (8) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      if (pix_clk !== ~pix_tick) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 inverted", bad, 0);

    // R9 mid-period write does not cut the running period
    wr(32'h0000_0008);
    measure(hi, lo, tk);
    while (pix_clk !== 1'b0) @(negedge clk);
    while (pix_clk !== 1'b1) @(negedge clk);
    hi = 1; lo = 0;
    wr(32'h0000_0000);
    while (pix_clk == 1'b1) begin hi++; @(negedge clk); end
    while (pix_clk == 1'b0) begin lo++; @(negedge clk); end
    chk(hi == 5 && lo == 5, "R9 old period kept", hi * 10 + lo, 55);
    measure(hi, lo, tk);
    chk(hi == 1 && lo == 1, "R9 new ratio applied", hi * 10 + lo, 11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule